// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Seconds Snapshot

This block keeps wall-clock time as two counters, a sub-second count in milliseconds and a whole-seconds count, both advanced from a slow, always-running tick. A divider inside the block turns a fixed number of ticks into one millisecond step. When the millisecond count rolls over from its last value back to zero, the seconds count advances by one. The block is meant to stay powered while the rest of the chip sleeps, and it serves as a persistent, monotonic time base.

Software reads the time through a small register bus. One read cannot return both counters at once, so a read of the milliseconds register also copies the seconds count into a separate snapshot register. Read the milliseconds first, then the snapshot. The two values then belong to the same instant, and the total time in milliseconds is snapshot × 1000 + milliseconds. The snapshot holds only one copy. If two agents interleave their read pairs, the second milliseconds read replaces the first agent's copy, so agents must not share the pair.

The bus accepts one request in each cycle in which `bus_valid_i` is high. `bus_ready_o` is held high, so there is never back-pressure. A read returns its data with `rd_valid_o` high for exactly one cycle, registered at the edge that accepts the request. The read returns the register's contents as they are after that same edge.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset the milliseconds count, the seconds count and the snapshot all read as zero, `rd_valid_o` is low and `bus_ready_o` is high.
- R2: Every TICKS_PER_MS cycles with `tick_i` high advance the milliseconds count by one. The count stays in 0..999 and goes from 999 to 0.
- R3: On the step where milliseconds go from 999 to 0, the seconds count rises by exactly one, and it goes from 0xFFFFFFFF to 0.
- R4: The register offsets are: live seconds at byte offset 0x08, seconds snapshot at 0x0C and milliseconds at 0x10. A read of any other offset returns 0. A read accepted at an edge sets `rd_valid_o` for one cycle, with data equal to the register after that edge.
- R5: A read of the milliseconds register loads the snapshot with the seconds value after the same edge. If that edge also wraps the milliseconds count, the snapshot holds the incremented seconds and the read returns 0.
- R6: Only a milliseconds read changes the snapshot. Reads of the live seconds, of the snapshot or of an unmapped offset, and the passage of time, leave it as it was.
- R7: A write to offset 0x08 loads the seconds count. When it meets a millisecond wrap on the same edge, the written value wins and no increment is added.
- R8: A write to offset 0x10 loads the milliseconds count with the write data, or with 0 when the data is 1000 or more. It also restarts the tick divider, and a coincident wrap does not advance the seconds.
- R9: Writes to the snapshot offset 0x0C and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable per slow-clock period, already synchronous to clk |
| bus_valid_i | input | 1 | Bus request present |
| bus_ready_o | output | 1 | Request accepted; always high |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle per accepted read |
| rd_data_o | output | DATA_W (32) | Read data |

## Verification
The assertions take for granted that `tick_i` is already synchronous to the block clock, that at most one bus request arrives in each cycle, and that write data for the milliseconds register stays within the 32-bit data width. The stimulus changes all inputs on the falling clock edge and issues one request at a time. Ticks are given as exact cycle counts, so the edge where a wrap lands can be placed on the same edge as a read or a write. That lets the cases where a tick and a bus access coincide be checked directly.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  localparam int unsigned OFS_SEC_LIVE = 32'h08;
  localparam int unsigned OFS_SEC_SNAP = 32'h0C;
  localparam int unsigned OFS_MSEC     = 32'h10;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_SNAP = 2'd2,
    SEL_MS   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_SEC_LIVE: s = SEL_SEC;
      OFS_SEC_SNAP: s = SEL_SNAP;
      OFS_MSEC:     s = SEL_MS;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned TICKS_PER_MS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic ms_en_o
);
  localparam int unsigned CW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  assign ms_en_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: the divider never leaves its counting range
  p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MS_PER_SEC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_en_i,
  input  logic              sec_wr_i,
  input  logic              ms_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ms_q_o,
  output logic [DATA_W-1:0] sec_q_o,
  output logic [DATA_W-1:0] ms_nx_o,
  output logic [DATA_W-1:0] sec_nx_o
);
  localparam logic [DATA_W-1:0] MS_LAST = DATA_W'(MS_PER_SEC - 1);

  logic [DATA_W-1:0] ms_q, sec_q;
  logic              wrap;

  assign wrap = ms_en_i && !ms_wr_i && (ms_q == MS_LAST);

  always_comb begin
    ms_nx_o  = ms_q;
    sec_nx_o = sec_q;
    if (ms_wr_i) begin
      ms_nx_o = (wdata_i <= MS_LAST) ? wdata_i : '0;
    end else if (ms_en_i) begin
      ms_nx_o = (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
    end
    if (sec_wr_i) begin
      sec_nx_o = wdata_i;
    end else if (wrap) begin
      sec_nx_o = sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      ms_q  <= ms_nx_o;
      sec_q <= sec_nx_o;
    end
  end

  assign ms_q_o  = ms_q;
  assign sec_q_o = sec_q;

  // R2: the sub-second count stays below one second
  p_ms_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MS_LAST);

  // R3: without a write, seconds hold or step by exactly one
  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_wr_i |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1));

  // R3: a millisecond step at the top of the range wraps and carries
  p_wrap_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_en_i && !ms_wr_i && !sec_wr_i && ms_q == MS_LAST)
      |=> (ms_q == '0) && (sec_q == $past(sec_q) + 1'b1));

  // R7: a seconds write lands as written
  p_sec_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr_i |=> sec_q == $past(wdata_i));

endmodule

// File: rtl/rtc_snap.sv
module rtc_snap #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] sec_nx_i,
  output logic [DATA_W-1:0] snap_o
);
  logic [DATA_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (capture_i) begin
      snap_q <= sec_nx_i;
    end
  end

  assign snap_o = snap_q;

  // R6: the snapshot moves only on a capture
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(snap_q));

endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock
  import rtc_shadow_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned TICKS_PER_MS = 32,
  parameter int unsigned MS_PER_SEC   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  reg_sel_e          sel;
  logic              rd_acc, wr_acc;
  logic              sec_wr, ms_wr, ms_rd;
  logic              ms_en;
  logic [DATA_W-1:0] ms_q, sec_q, ms_nx, sec_nx, snap_q;
  logic [DATA_W-1:0] rd_mux;

  assign bus_ready_o = 1'b1;
  assign sel    = decode_ofs(32'(bus_addr_i));
  assign rd_acc = bus_valid_i && !bus_write_i;
  assign wr_acc = bus_valid_i && bus_write_i;
  assign sec_wr = wr_acc && (sel == SEL_SEC);
  assign ms_wr  = wr_acc && (sel == SEL_MS);
  assign ms_rd  = rd_acc && (sel == SEL_MS);

  rtc_tick_div #(.TICKS_PER_MS(TICKS_PER_MS)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .restart_i(ms_wr),
    .ms_en_o  (ms_en)
  );

  rtc_time_core #(.DATA_W(DATA_W), .MS_PER_SEC(MS_PER_SEC)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_en_i (ms_en),
    .sec_wr_i(sec_wr),
    .ms_wr_i (ms_wr),
    .wdata_i (bus_wdata_i),
    .ms_q_o  (ms_q),
    .sec_q_o (sec_q),
    .ms_nx_o (ms_nx),
    .sec_nx_o(sec_nx)
  );

  rtc_snap #(.DATA_W(DATA_W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture_i(ms_rd),
    .sec_nx_i (sec_nx),
    .snap_o   (snap_q)
  );

  always_comb begin
    case (sel)
      SEL_SEC:  rd_mux = sec_nx;
      SEL_SNAP: rd_mux = snap_q;
      SEL_MS:   rd_mux = ms_nx;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_acc;
      if (rd_acc) rd_data_o <= rd_mux;
    end
  end

  // R4: one response per accepted read, none otherwise
  p_rd_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid_o);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid_o);

  // R5: after a milliseconds read the snapshot equals live seconds
  p_snap_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ms_rd |=> snap_q == sec_q);

  // R5: the returned milliseconds equal the live count after the edge
  p_ms_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ms_rd |=> rd_data_o == ms_q);

endmodule

// File: tb/rtc_shadow_clock_tb.sv
module rtc_shadow_clock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bvalid = 1'b0;
  logic        bready;
  logic        bwrite = 1'b0;
  logic [7:0]  baddr = '0;
  logic [31:0] bwdata = '0;
  logic        rvalid;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_shadow_clock #(.ADDR_W(8), .DATA_W(32), .TICKS_PER_MS(TPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bus_valid_i(bvalid), .bus_ready_o(bready), .bus_write_i(bwrite),
    .bus_addr_i(baddr), .bus_wdata_i(bwdata),
    .rd_valid_o(rvalid), .rd_data_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one bus cycle, optionally with a tick on the same edge; called at negedge
  task automatic bus_op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic tk);
    bvalid = 1'b1; bwrite = wr; baddr = a; bwdata = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    bvalid = 1'b0; bwrite = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_op(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_op(1'b0, a, '0, 1'b0);
    chk("R4 rd_valid", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rd_valid low", {31'd0, rvalid}, 32'd0);
    chk("R1 ready high", {31'd0, bready}, 32'd1);
    rd(8'h10, v); chk("R1 ms zero", v, 0);
    rd(8'h0C, v); chk("R1 snapshot zero", v, 0);
    rd(8'h08, v); chk("R1 seconds zero", v, 0);
    @(negedge clk);
    chk("R4 rd_valid one cycle", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(8'h10, 0); wr(8'h08, 5);
    ticks(10 * TPM);
    rd(8'h10, v); chk("R2 ms after 40 ticks", v, 10);
    ticks(TPM - 1);
    rd(8'h10, v); chk("R2 partial ms holds", v, 10);
    ticks(1);
    rd(8'h10, v); chk("R2 ms step", v, 11);
    rd(8'h08, v); chk("R2 seconds unchanged", v, 5);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(8'h10, 998);
    ticks(2 * TPM);
    rd(8'h10, v); chk("R2 wrap to zero", v, 0);
    rd(8'h0C, v); chk("R3 carry in snapshot", v, 6);
    rd(8'h08, v); chk("R3 live seconds", v, 6);
  endtask

  task automatic t_coincident();
    logic [31:0] v;
    wr(8'h10, 999);
    ticks(TPM - 1);
    bus_op(1'b0, 8'h10, '0, 1'b1);
    chk("R5 ms read on wrap", rdata, 0);
    rd(8'h0C, v); chk("R5 snapshot takes post-wrap seconds", v, 7);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(8'h08, 100);
    rd(8'h0C, v); chk("R6 snapshot kept after seconds write", v, 7);
    rd(8'h08, v); chk("R4 live seconds read", v, 100);
    rd(8'h04, v); chk("R4 unmapped reads zero", v, 0);
    ticks(3 * TPM);
    rd(8'h0C, v); chk("R6 snapshot kept over time and reads", v, 7);
  endtask

  task automatic t_ignored_writes();
    logic [31:0] v;
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, v); chk("R9 snapshot write ignored", v, 7);
    wr(8'h14, 32'h1234);
    rd(8'h08, v); chk("R9 unmapped write leaves seconds", v, 100);
    rd(8'h10, v); chk("R9 unmapped write leaves ms", v, 3);
  endtask

  task automatic t_sec_write_race();
    logic [31:0] v;
    wr(8'h10, 999);
    ticks(TPM - 1);
    bus_op(1'b1, 8'h08, 50, 1'b1);
    rd(8'h08, v); chk("R7 write beats carry", v, 50);
    rd(8'h10, v); chk("R7 ms still wrapped", v, 0);
  endtask

  task automatic t_ms_write_race();
    logic [31:0] v;
    wr(8'h10, 999);
    ticks(TPM - 1);
    bus_op(1'b1, 8'h10, 7, 1'b1);
    rd(8'h10, v); chk("R8 ms write wins", v, 7);
    rd(8'h08, v); chk("R8 no carry on ms write", v, 50);
    ticks(TPM - 1);
    rd(8'h10, v); chk("R8 divider restarted", v, 7);
    ticks(1);
    rd(8'h10, v); chk("R8 first step after restart", v, 8);
    wr(8'h10, 1000);
    rd(8'h10, v); chk("R8 out-of-range write loads zero", v, 0);
  endtask

  task automatic t_sec_rollover();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h10, 999);
    ticks(TPM);
    rd(8'h10, v); chk("R3 ms wrap", v, 0);
    rd(8'h0C, v); chk("R3 seconds roll over", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_coincident();
    t_hold();
    t_ignored_writes();
    t_sec_write_race();
    t_ms_write_race();
    t_sec_rollover();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule